// File: doc/BRIEF.md
# Shared-Bus Multi-Step Processor Core

This block is a tiny 16-bit execution core. All data moves over one internal bus. It has eight general registers, an operand latch A, a result latch G, a 9-bit instruction word and an adder/subtractor. A single input port carries two kinds of value:

- The instruction word, which is taken from the top nine bits of the port.
- For the immediate-load instruction, the 16-bit constant, which arrives on the following cycle.

A host raises `run` for one cycle to start exactly one instruction. It watches `done`, which is high during the last step of that instruction. The control steps through a small 2-bit phase count. Each step, a fixed table keyed by the opcode picks one bus source and the registers that capture the bus. Moves finish in two steps and arithmetic in four.

The live bus value and all eight general registers are visible at the ports. A host or a surrounding test harness can therefore follow every transfer.

Top module: `stepbus_core`

## Requirements
- R1: While `rstN` is low, the phase count, the instruction word and all registers are zero, `done` is low and `busOut` reads zero. After release the core is idle until `run` is high.
- R2: A cycle with `run` high while idle is step T0. On T0 the core captures din[15:7] as opcode = bits [8:6], destination x = bits [5:3] and source y = bits [2:0]. During T0 nothing drives the bus, so `busOut` is zero, and `done` is low.
- R3: Opcode 000 (move): on the step after T0, `busOut` equals register y, `done` is high, and register x holds that value afterwards.
- R4: Opcode 001 (immediate): on the step after T0, `busOut` equals `din`, `done` is high, and register x holds the `din` value afterwards.
- R5: Opcode 010 (add) runs four steps. On T1 the bus shows register x. On T2 it shows register y. On T3 it shows (x + y) mod 2^16 with `done` high, and register x holds that sum afterwards.
- R6: Opcode 011 (subtract) follows the same four steps as R5, with the result (x − y) mod 2^16.
- R7: `run` is ignored while an instruction is in progress. Holding `run` high through an instruction executes it once.
- R8: Opcodes 1xx are no-ops. They end on the step after T0 with `done` low, the bus at zero and no register changed.
- R9: `done` is high for exactly one cycle per completed move, immediate or arithmetic instruction, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start strobe, sampled while idle |
| din | input | 16 | Instruction word (bits 15:7) or immediate value |
| busOut | output | 16 | Current value on the shared bus |
| done | output | 1 | High during the final step of an instruction |
| regsOut | output | 128 | Register i in bits [16*i+15 : 16*i] |

## Verification
A wrong phase count or a bad decode shows up on `busOut` within the same step, as the wrong source value or zero. It also shows as `done` arriving early, late or twice. A lost or doubled register load appears on `regsOut` one cycle after the step that should have written it. A stale instruction word kept after completion shows as a second execution when `run` is held high. That second execution moves the destination register again within four cycles.

// File: rtl/stepbus_pkg.sv
package stepbus_pkg;
  localparam int REG_CNT = 8;
  localparam int SEL_W   = $clog2(REG_CNT);
  localparam int OPC_W   = 3;
  localparam int IR_W    = OPC_W + 2 * SEL_W;
  localparam int STEP_W  = 2;

  localparam logic [OPC_W-1:0] OPC_MOV = 3'd0;
  localparam logic [OPC_W-1:0] OPC_IMM = 3'd1;
  localparam logic [OPC_W-1:0] OPC_ADD = 3'd2;
  localparam logic [OPC_W-1:0] OPC_SUB = 3'd3;

  // strobes from sequencer to datapath for one step
  typedef struct packed {
    logic [REG_CNT-1:0] rOut;
    logic [REG_CNT-1:0] rIn;
    logic               gOut;
    logic               dinOut;
    logic               aIn;
    logic               gIn;
    logic               subSel;
    logic               done;
  } ctl_t;
endpackage

// File: rtl/stepbus_ctrl.sv
module stepbus_ctrl
  import stepbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic [DATA_W-1:0]    din,
  output ctl_t                 ctl,
  output logic                 busy,
  output logic [STEP_W-1:0]    step,
  output logic [IR_W-1:0]      irWord
);
  logic [OPC_W-1:0] opc;
  logic [SEL_W-1:0] xSel;
  logic [SEL_W-1:0] ySel;
  logic             lastStep;
  logic             isArith;

  assign opc     = irWord[IR_W-1 -: OPC_W];
  assign xSel    = irWord[2*SEL_W-1 -: SEL_W];
  assign ySel    = irWord[SEL_W-1:0];
  assign isArith = (opc == OPC_ADD) || (opc == OPC_SUB);

  always_comb begin
    ctl      = '0;
    lastStep = 1'b0;
    if (busy) begin
      unique case (step)
        STEP_W'(1): begin
          if (opc == OPC_MOV) begin
            ctl.rOut[ySel] = 1'b1;
            ctl.rIn[xSel]  = 1'b1;
            ctl.done       = 1'b1;
            lastStep       = 1'b1;
          end else if (opc == OPC_IMM) begin
            ctl.dinOut     = 1'b1;
            ctl.rIn[xSel]  = 1'b1;
            ctl.done       = 1'b1;
            lastStep       = 1'b1;
          end else if (isArith) begin
            ctl.rOut[xSel] = 1'b1;
            ctl.aIn        = 1'b1;
          end else begin
            lastStep       = 1'b1;
          end
        end
        STEP_W'(2): begin
          if (isArith) begin
            ctl.rOut[ySel] = 1'b1;
            ctl.gIn        = 1'b1;
            ctl.subSel     = (opc == OPC_SUB);
          end else begin
            lastStep       = 1'b1;
          end
        end
        STEP_W'(3): begin
          if (isArith) begin
            ctl.gOut       = 1'b1;
            ctl.rIn[xSel]  = 1'b1;
            ctl.done       = 1'b1;
          end
          lastStep = 1'b1;
        end
        default: lastStep = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      step   <= '0;
      irWord <= '0;
    end else if (!busy) begin
      if (run) begin
        irWord <= din[DATA_W-1 -: IR_W];
        busy   <= 1'b1;
        step   <= STEP_W'(1);
      end
    end else if (lastStep) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + STEP_W'(1);
    end
  end
endmodule

// File: rtl/stepbus_datapath.sv
module stepbus_datapath
  import stepbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_t                       ctl,
  input  logic [DATA_W-1:0]          din,
  output logic [DATA_W-1:0]          busVal,
  output logic [REG_CNT*DATA_W-1:0]  regsFlat
);
  logic [DATA_W-1:0] gpr [REG_CNT];
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] resG;
  logic [DATA_W-1:0] aluOut;

  // priority: G first, then R0..R7, then din, else zero
  always_comb begin
    busVal = '0;
    if (ctl.dinOut) busVal = din;
    for (int i = REG_CNT - 1; i >= 0; i--) begin
      if (ctl.rOut[i]) busVal = gpr[i];
    end
    if (ctl.gOut) busVal = resG;
  end

  assign aluOut = ctl.subSel ? (opA - busVal) : (opA + busVal);

  for (genvar i = 0; i < REG_CNT; i++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          gpr[i] <= '0;
      else if (ctl.rIn[i]) gpr[i] <= busVal;
    end
    assign regsFlat[i*DATA_W +: DATA_W] = gpr[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA  <= '0;
      resG <= '0;
    end else begin
      if (ctl.aIn) opA  <= busVal;
      if (ctl.gIn) resG <= aluOut;
    end
  end
endmodule

// File: rtl/stepbus_core.sv
module stepbus_core
  import stepbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      run,
  input  logic [DATA_W-1:0]         din,
  output logic [DATA_W-1:0]         busOut,
  output logic                      done,
  output logic [REG_CNT*DATA_W-1:0] regsOut
);
  ctl_t              ctl;
  logic              busy;
  logic [STEP_W-1:0] step;
  logic [IR_W-1:0]   irWord;

  stepbus_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .run(run), .din(din),
    .ctl(ctl), .busy(busy), .step(step), .irWord(irWord)
  );

  stepbus_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .din(din),
    .busVal(busOut), .regsFlat(regsOut)
  );

  assign done = ctl.done;
endmodule

// File: rtl/stepbus_chk.sv
module stepbus_chk
  import stepbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic [DATA_W-1:0] busOut,
  input logic              busy,
  input logic [STEP_W-1:0] step,
  input logic [IR_W-1:0]   irWord,
  input ctl_t              ctl
);
  logic [OPC_W-1:0] opc;
  assign opc = irWord[IR_W-1 -: OPC_W];

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busOut == '0 && !done));

  a_r7_ir_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(irWord));

  a_r3_move_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && step == STEP_W'(1) && (opc == OPC_MOV || opc == OPC_IMM)) |-> done);

  a_r5_long_only_arith: assert property (@(posedge clk) disable iff (!rstN)
    (busy && step >= STEP_W'(2)) |-> (opc == OPC_ADD || opc == OPC_SUB));

  a_r8_noop_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opc[OPC_W-1]) |-> (ctl.rIn == '0 && !ctl.aIn && !ctl.gIn && !done));

  a_r5_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.rOut, ctl.gOut, ctl.dinOut}));
endmodule

bind stepbus_core stepbus_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .done(done), .busOut(busOut),
  .busy(busy), .step(step), .irWord(irWord), .ctl(ctl)
);

// File: tb/tb_stepbus_core.sv
`timescale 1ns/1ps
module tb_stepbus_core;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         run = 1'b0;
  logic [15:0]  din = '0;
  logic [15:0]  busOut;
  logic         done;
  logic [127:0] regsOut;

  int total = 0;
  int bad = 0;
  logic [15:0] mdl [8];

  stepbus_core dut (.clk(clk), .rstN(rstN), .run(run), .din(din),
                    .busOut(busOut), .done(done), .regsOut(regsOut));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] arith(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    return (op == 3'd2) ? a + b : a - b;
  endfunction

  task automatic checkRegs(input string req);
    for (int i = 0; i < 8; i++) check(req, regsOut[i*16 +: 16], mdl[i]);
  endtask

  task automatic doInstr(input logic [2:0] op, input logic [2:0] x, input logic [2:0] y,
                         input logic [15:0] imm, input bit hold);
    logic [15:0] res;
    @(negedge clk);
    run = 1'b1;
    din = {op, x, y, 7'($urandom)};
    #1;
    check("R2 T0 bus", busOut, 16'h0);
    check("R2 T0 done", done, 1'b0);
    @(negedge clk);
    run = hold;
    din = imm;
    #1;
    case (op)
      3'd0: begin
        check("R3 mv bus", busOut, mdl[y]);
        check("R3 mv done", done, 1'b1);
        mdl[x] = mdl[y];
      end
      3'd1: begin
        check("R4 imm bus", busOut, imm);
        check("R4 imm done", done, 1'b1);
        mdl[x] = imm;
      end
      3'd2, 3'd3: begin
        check("R5 T1 bus", busOut, mdl[x]);
        check("R9 T1 done", done, 1'b0);
        res = arith(op, mdl[x], mdl[y]);
        @(negedge clk);
        din = 16'($urandom);
        #1;
        check("R5 T2 bus", busOut, mdl[y]);
        check("R9 T2 done", done, 1'b0);
        @(negedge clk);
        #1;
        check(op == 3'd2 ? "R5 add result" : "R6 sub result", busOut, res);
        check("R9 T3 done", done, 1'b1);
        mdl[x] = res;
      end
      default: begin
        check("R8 noop bus", busOut, 16'h0);
        check("R8 noop done", done, 1'b0);
      end
    endcase
    @(negedge clk);
    run = 1'b0;
    #1;
    check("R7 R9 idle after end", {busOut, done}, 17'h0);
    checkRegs(op[2] ? "R8 regs" : "R3 R4 R5 R6 R7 regs");
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset bus", busOut, 16'h0);
    check("R1 reset done", done, 1'b0);
    checkRegs("R1 reset regs");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 idle bus", busOut, 16'h0);

    doInstr(3'd1, 3'd0, 3'd0, 16'd6, 1'b0);
    doInstr(3'd0, 3'd1, 3'd0, 16'h0, 1'b0);
    doInstr(3'd3, 3'd0, 3'd1, 16'h0, 1'b0);
    doInstr(3'd2, 3'd0, 3'd1, 16'h0, 1'b0);
    doInstr(3'd1, 3'd7, 3'd0, 16'hFFFF, 1'b0);
    doInstr(3'd2, 3'd7, 3'd7, 16'h0, 1'b0);
    doInstr(3'd1, 3'd2, 3'd0, 16'h0000, 1'b0);
    doInstr(3'd3, 3'd2, 3'd7, 16'h0, 1'b0);
    check("R6 wrap value", regsOut[2*16 +: 16], 16'h0002);
    doInstr(3'd5, 3'd3, 3'd7, 16'hAAAA, 1'b0);
    doInstr(3'd2, 3'd1, 3'd0, 16'h0, 1'b1);
    doInstr(3'd0, 3'd4, 3'd1, 16'h0, 1'b1);

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = ($urandom % 5 == 4) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      doInstr(op, 3'($urandom), 3'($urandom), 16'($urandom), 1'($urandom));
    end

    // reset in the middle of an add
    @(negedge clk);
    run = 1'b1;
    din = {3'd2, 3'd1, 3'd2, 7'h0};
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    check("R1 mid reset bus", busOut, 16'h0);
    check("R1 mid reset done", done, 1'b0);
    checkRegs("R1 mid reset regs");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 idle after reset", done, 1'b0);
    doInstr(3'd1, 3'd3, 3'd0, 16'h1234, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule